// File: doc/BRIEF.md
# Two-Stage Watchdog Register Front End

This block is the register front end for a two-stage watchdog countdown core. It decodes a simple access strobe that carries a valid bit, a write bit, a space select, an address, a size code and write data. The strobe reaches two spaces. The first is a configuration space holding a 16-bit control register and an 8-bit lock register. The second is a 16-byte memory window holding the two preload values and a kick/flag register. All control fields, both preload values and two single-cycle pulses (kick and flag-clear) are driven from registers straight into the countdown core.

Writes to the protected window registers need a handshake first. Two byte values are written to the kick offset: first 0x80, then 0x86. That opens the window for exactly one following word or dword write. The lock register becomes frozen once its lock bit is set. Read data is registered, and it reports the previous-reboot flag that the core supplies.

Size codes on `bus_size` are 0 = byte, 1 = word (16-bit), 2 = dword (32-bit) and 3 = reserved. `bus_cfg` = 1 selects the configuration space and 0 selects the window.

Top module: `wd_regfile`

## Requirements
- R1: A window write at offset 0x0C with write data exactly 0x80 (byte, word or dword size) arms the handshake. A following window write of exactly 0x86 at 0x0C opens it, but only while it is armed. A 0x86 write while not armed has no effect. Other writes leave the armed state in place.
- R2: Once the handshake is open, the next window word or dword write consumes it, whatever its offset and except for a new 0x80 arm write, and returns the handshake to idle. Byte writes, reads and configuration accesses leave it open.
- R3: A consuming dword write at offset 0x00 loads the stage-1 preload, and one at 0x04 loads the stage-2 preload, each with write data bits [19:0]. Preload writes made without an open handshake have no effect.
- R4: A consuming word write at 0x0C with bit 8 set raises `kick_pulse` for exactly the one cycle after the write.
- R5: A consuming word write at 0x0C with bit 9 or bit 12 set raises `flag_clr_pulse` for exactly the one cycle after the write.
- R6: A window word read at 0x0C returns 0x1200 when `prev_reboot_in` is high and 0 when it is low. Every other window read returns 0.
- R7: A configuration word write at 0x60 sets `reboot_en` to the inverse of bit 5, `fast_scale` to bit 2 and `irq_type` to bits [1:0]. A word read at 0x60 returns the same encoding.
- R8: A configuration byte write at 0x68 sets `wd_lock` from bit 0, `wd_enable` from bit 1 and `free_run` from bit 2. A byte read at 0x68 returns them at the same bit positions.
- R9: While `wd_lock` is 1, writes to 0x68 change nothing until reset.
- R10: Configuration accesses of the wrong size, at other offsets, or with the reserved size change nothing and read as 0. Reserved-size window writes are ignored.
- R11: Reset sets `reboot_en` = 1, `fast_scale` = 0, `irq_type` = 0, lock, enable and free-run to 0, both preloads to 0xFFFFF, the pulses low, `bus_rdata` to 0, and the handshake to idle.
- R12: `bus_rdata` takes the read result in the cycle after a read access and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cfg | input | 1 | 1 = configuration space, 0 = memory window |
| bus_addr | input | 8 | Byte offset |
| bus_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| prev_reboot_in | input | 1 | Previous-reboot flag from the core |
| reboot_en | output | 1 | Reboot on second-stage expiry |
| fast_scale | output | 1 | Fast countdown clock select |
| irq_type | output | 2 | First-stage interrupt type |
| wd_lock | output | 1 | Lock register frozen |
| wd_enable | output | 1 | Countdown enabled |
| free_run | output | 1 | Restart after second-stage expiry |
| preload1 | output | 20 | Stage-1 preload |
| preload2 | output | 20 | Stage-2 preload |
| kick_pulse | output | 1 | Keep-alive reload pulse |
| flag_clr_pulse | output | 1 | Previous-reboot flag clear pulse |

## Verification
The handshake is driven with directed orders that separate a correct sequence from near misses. These include 0x86 without a prior 0x80, junk byte writes while armed, a byte write while open that must not consume the unlock, and a second protected write that must not reuse an old unlock. Random traffic then mixes the magic values, the kick and clear bit patterns, wide random words and all four size codes over the hot offsets. This exposes wrong size gating and wrong single-use accounting. A reference model in the bench predicts every output after each access. The lock register is driven to a frozen state and then rewritten to show that the freeze holds.

// File: rtl/wd_regfile_pkg.sv
package wd_regfile_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int PRELOAD_W = 20;
    localparam int IRQ_W     = 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_ARMED = 2'd1,
        UL_OPEN  = 2'd2
    } unlock_e;

    // offsets whose values software and the core rely on
    localparam logic [7:0] OFS_PRE1   = 8'h00;
    localparam logic [7:0] OFS_PRE2   = 8'h04;
    localparam logic [7:0] OFS_KICK   = 8'h0C;
    localparam logic [7:0] OFS_CTRL   = 8'h60;
    localparam logic [7:0] OFS_LOCK   = 8'h68;

    localparam logic [31:0] MAGIC_ARM  = 32'h0000_0080;
    localparam logic [31:0] MAGIC_OPEN = 32'h0000_0086;

    // control register bits
    localparam int CTRL_NOREBOOT_BIT = 5;
    localparam int CTRL_FAST_BIT     = 2;
    // lock register bits
    localparam int LK_LOCK_BIT = 0;
    localparam int LK_EN_BIT   = 1;
    localparam int LK_FREE_BIT = 2;
    // kick register bits
    localparam int KK_KICK_BIT    = 8;
    localparam int KK_FLAG_BIT    = 9;
    localparam int KK_FLAG_ALTBIT = 12;

endpackage

// File: rtl/wd_unlock_seq.sv
module wd_unlock_seq
    import wd_regfile_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_win,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic [DW-1:0] wdata,
    output logic          grant
);

    typedef struct packed {
        unlock_e st;
    } ul_state_t;

    ul_state_t state_d, state_q;

    logic sized_wr;
    logic at_kick;
    logic wide_wr;
    logic hit_arm;
    logic hit_open;

    always_comb begin
        sized_wr = wr_win && (size != SZ_RSVD);
        wide_wr  = wr_win && ((size == SZ_WORD) || (size == SZ_DWORD));
        at_kick  = (addr == AW'(OFS_KICK));
        hit_arm  = sized_wr && at_kick && (wdata == DW'(MAGIC_ARM));
        hit_open = sized_wr && at_kick && (wdata == DW'(MAGIC_OPEN))
                   && (state_q.st == UL_ARMED);
        grant    = wide_wr && (state_q.st == UL_OPEN) && !hit_arm;

        state_d = state_q;
        if (hit_arm) begin
            state_d.st = UL_ARMED;
        end else if (hit_open) begin
            state_d.st = UL_OPEN;
        end else if (grant) begin
            state_d.st = UL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.st <= UL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    AST_NO_SKIP_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == UL_IDLE) |=> (state_q.st != UL_OPEN)); // R1

    AST_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (state_q.st == UL_IDLE)); // R2

endmodule

// File: rtl/wd_mmio_window.sv
module wd_mmio_window
    import wd_regfile_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PRELOAD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant,
    input  logic          rd_win,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic [DW-1:0] wdata,
    input  logic          prev_flag,
    output logic [PW-1:0] preload1,
    output logic [PW-1:0] preload2,
    output logic          kick_pulse,
    output logic          flag_clr_pulse,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [PW-1:0] pre1;
        logic [PW-1:0] pre2;
        logic          kick;
        logic          clr;
    } win_state_t;

    win_state_t st_d, st_q;

    logic at_kick;
    logic unused_hi;

    assign unused_hi = ^wdata;

    always_comb begin
        at_kick = (addr == AW'(OFS_KICK));

        st_d      = st_q;
        st_d.kick = 1'b0;
        st_d.clr  = 1'b0;
        if (grant) begin
            if (size == SZ_DWORD) begin
                if (addr == AW'(OFS_PRE1)) begin
                    st_d.pre1 = wdata[PW-1:0];
                end
                if (addr == AW'(OFS_PRE2)) begin
                    st_d.pre2 = wdata[PW-1:0];
                end
            end
            if ((size == SZ_WORD) && at_kick) begin
                st_d.kick = wdata[KK_KICK_BIT];
                st_d.clr  = wdata[KK_FLAG_BIT] | wdata[KK_FLAG_ALTBIT];
            end
        end

        rdata = '0;
        if (rd_win && (size == SZ_WORD) && at_kick) begin
            rdata[KK_FLAG_BIT]    = prev_flag;
            rdata[KK_FLAG_ALTBIT] = prev_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pre1 <= '1;
            st_q.pre2 <= '1;
            st_q.kick <= 1'b0;
            st_q.clr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign preload1       = st_q.pre1;
    assign preload2       = st_q.pre2;
    assign kick_pulse     = st_q.kick;
    assign flag_clr_pulse = st_q.clr;

    AST_PRELOAD_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> ($stable(st_q.pre1) && $stable(st_q.pre2))); // R3

    AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.kick |=> !st_q.kick); // R4

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr |=> !st_q.clr); // R5

endmodule

// File: rtl/wd_cfg_space.sv
module wd_cfg_space
    import wd_regfile_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int IW = IRQ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cfg,
    input  logic          rd_cfg,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic [DW-1:0] wdata,
    output logic          reboot_en,
    output logic          fast_scale,
    output logic [IW-1:0] irq_type,
    output logic          wd_lock,
    output logic          wd_enable,
    output logic          free_run,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic          reboot;
        logic          fast;
        logic [IW-1:0] irq;
        logic          lock;
        logic          en;
        logic          free;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic ctrl_hit;
    logic lock_hit;
    logic unused_wd;

    assign unused_wd = ^wdata;

    always_comb begin
        ctrl_hit = (addr == AW'(OFS_CTRL)) && (size == SZ_WORD);
        lock_hit = (addr == AW'(OFS_LOCK)) && (size == SZ_BYTE);

        st_d = st_q;
        if (wr_cfg && ctrl_hit) begin
            st_d.reboot = !wdata[CTRL_NOREBOOT_BIT];
            st_d.fast   = wdata[CTRL_FAST_BIT];
            st_d.irq    = wdata[IW-1:0];
        end
        if (wr_cfg && lock_hit && !st_q.lock) begin
            st_d.lock = wdata[LK_LOCK_BIT];
            st_d.en   = wdata[LK_EN_BIT];
            st_d.free = wdata[LK_FREE_BIT];
        end

        rdata = '0;
        if (rd_cfg && ctrl_hit) begin
            rdata[CTRL_NOREBOOT_BIT] = !st_q.reboot;
            rdata[CTRL_FAST_BIT]     = st_q.fast;
            rdata[IW-1:0]            = st_q.irq;
        end
        if (rd_cfg && lock_hit) begin
            rdata[LK_LOCK_BIT] = st_q.lock;
            rdata[LK_EN_BIT]   = st_q.en;
            rdata[LK_FREE_BIT] = st_q.free;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.reboot <= 1'b1;
            st_q.fast   <= 1'b0;
            st_q.irq    <= '0;
            st_q.lock   <= 1'b0;
            st_q.en     <= 1'b0;
            st_q.free   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reboot_en  = st_q.reboot;
    assign fast_scale = st_q.fast;
    assign irq_type   = st_q.irq;
    assign wd_lock    = st_q.lock;
    assign wd_enable  = st_q.en;
    assign free_run   = st_q.free;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock); // R9

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> ($stable(st_q.en) && $stable(st_q.free))); // R9

    AST_RSVD_SIZE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && (size == SZ_RSVD)) |=> $stable(st_q)); // R10

endmodule

// File: rtl/wd_regfile.sv
module wd_regfile
    import wd_regfile_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PRELOAD_W,
    parameter int IW = IRQ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic          bus_cfg,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          prev_reboot_in,
    output logic          reboot_en,
    output logic          fast_scale,
    output logic [IW-1:0] irq_type,
    output logic          wd_lock,
    output logic          wd_enable,
    output logic          free_run,
    output logic [PW-1:0] preload1,
    output logic [PW-1:0] preload2,
    output logic          kick_pulse,
    output logic          flag_clr_pulse
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    logic          wr_win, rd_win, wr_cfg, rd_cfg, rd_any;
    logic          grant;
    logic [DW-1:0] win_rdata;
    logic [DW-1:0] cfg_rdata;

    always_comb begin
        rd_any = bus_valid && !bus_write;
        wr_win = bus_valid && bus_write && !bus_cfg;
        rd_win = rd_any && !bus_cfg;
        wr_cfg = bus_valid && bus_write && bus_cfg;
        rd_cfg = rd_any && bus_cfg;
    end

    wd_unlock_seq #(.AW(AW), .DW(DW)) u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_win(wr_win),
        .addr  (bus_addr),
        .size  (bus_size),
        .wdata (bus_wdata),
        .grant (grant)
    );

    wd_mmio_window #(.AW(AW), .DW(DW), .PW(PW)) u_window (
        .clk           (clk),
        .rst_n         (rst_n),
        .grant         (grant),
        .rd_win        (rd_win),
        .addr          (bus_addr),
        .size          (bus_size),
        .wdata         (bus_wdata),
        .prev_flag     (prev_reboot_in),
        .preload1      (preload1),
        .preload2      (preload2),
        .kick_pulse    (kick_pulse),
        .flag_clr_pulse(flag_clr_pulse),
        .rdata         (win_rdata)
    );

    wd_cfg_space #(.AW(AW), .DW(DW), .IW(IW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cfg    (wr_cfg),
        .rd_cfg    (rd_cfg),
        .addr      (bus_addr),
        .size      (bus_size),
        .wdata     (bus_wdata),
        .reboot_en (reboot_en),
        .fast_scale(fast_scale),
        .irq_type  (irq_type),
        .wd_lock   (wd_lock),
        .wd_enable (wd_enable),
        .free_run  (free_run),
        .rdata     (cfg_rdata)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_any) begin
            rd_d.rdata = bus_cfg ? cfg_rdata : win_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q.rdata <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(bus_rdata)); // R12

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_win |=> (!kick_pulse && !flag_clr_pulse)); // R4

endmodule

// File: tb/wd_regfile_bench.sv
module wd_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_cfg = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        prev_reboot_in = 1'b0;
    logic        reboot_en, fast_scale, wd_lock, wd_enable, free_run;
    logic [1:0]  irq_type;
    logic [19:0] preload1, preload2;
    logic        kick_pulse, flag_clr_pulse;

    always #10 clk = ~clk;

    wd_regfile u_wd_regfile (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_cfg(bus_cfg), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prev_reboot_in(prev_reboot_in), .reboot_en(reboot_en),
        .fast_scale(fast_scale), .irq_type(irq_type), .wd_lock(wd_lock),
        .wd_enable(wd_enable), .free_run(free_run), .preload1(preload1),
        .preload2(preload2), .kick_pulse(kick_pulse),
        .flag_clr_pulse(flag_clr_pulse)
    );

    int    errs = 0;
    int    checks = 0;
    string cur_tag = "R11";

    // reference model state
    int        m_ul;
    bit        m_reboot, m_fast, m_lock, m_en, m_free, e_kick, e_clr;
    bit [1:0]  m_irq;
    bit [19:0] m_p1, m_p2;
    bit [31:0] m_rd;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R7 reboot_en", 32'(reboot_en), 32'(m_reboot));
        chk("R7 fast_scale", 32'(fast_scale), 32'(m_fast));
        chk("R7 irq_type", 32'(irq_type), 32'(m_irq));
        chk("R8 wd_lock", 32'(wd_lock), 32'(m_lock));
        chk("R8 wd_enable", 32'(wd_enable), 32'(m_en));
        chk("R8 free_run", 32'(free_run), 32'(m_free));
        chk("R3 preload1", 32'(preload1), 32'(m_p1));
        chk("R3 preload2", 32'(preload2), 32'(m_p2));
        chk("R4 kick_pulse", 32'(kick_pulse), 32'(e_kick));
        chk("R5 flag_clr_pulse", 32'(flag_clr_pulse), 32'(e_clr));
        chk("R12 bus_rdata", bus_rdata, m_rd);
    endtask

    task automatic model_reset();
        m_ul = 0; m_reboot = 1; m_fast = 0; m_irq = 0;
        m_lock = 0; m_en = 0; m_free = 0;
        m_p1 = 20'hFFFFF; m_p2 = 20'hFFFFF; m_rd = 0;
        e_kick = 0; e_clr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all();
    endtask

    task automatic model_apply(bit cfg, bit wr, bit [7:0] a, bit [1:0] sz,
                               bit [31:0] d, bit flag);
        e_kick = 0;
        e_clr  = 0;
        if (cfg) begin
            if (wr) begin
                if (a == 8'h60 && sz == 2'd1) begin
                    m_reboot = !d[5]; m_fast = d[2]; m_irq = d[1:0];
                end else if (a == 8'h68 && sz == 2'd0 && !m_lock) begin
                    m_lock = d[0]; m_en = d[1]; m_free = d[2];
                end
            end else begin
                m_rd = 0;
                if (a == 8'h60 && sz == 2'd1) begin
                    m_rd[5] = !m_reboot; m_rd[2] = m_fast; m_rd[1:0] = m_irq;
                end else if (a == 8'h68 && sz == 2'd0) begin
                    m_rd[0] = m_lock; m_rd[1] = m_en; m_rd[2] = m_free;
                end
            end
        end else begin
            if (wr) begin
                if (sz != 2'd3) begin
                    if (a == 8'h0C && d == 32'h80) begin
                        m_ul = 1;
                    end else if (a == 8'h0C && d == 32'h86 && m_ul == 1) begin
                        m_ul = 2;
                    end else if (m_ul == 2 && sz != 2'd0) begin
                        if (sz == 2'd2 && a == 8'h00) m_p1 = d[19:0];
                        if (sz == 2'd2 && a == 8'h04) m_p2 = d[19:0];
                        if (sz == 2'd1 && a == 8'h0C) begin
                            e_kick = d[8];
                            e_clr  = d[9] | d[12];
                        end
                        m_ul = 0;
                    end
                end
            end else begin
                m_rd = (a == 8'h0C && sz == 2'd1 && flag) ? 32'h1200 : 32'h0;
            end
        end
    endtask

    task automatic acc(bit cfg, bit wr, bit [7:0] a, bit [1:0] sz, bit [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_cfg = cfg; bus_write = wr;
        bus_addr = a; bus_size = sz; bus_wdata = d;
        model_apply(cfg, wr, a, sz, d, prev_reboot_in);
        @(negedge clk);
        bus_valid = 1'b0;
        check_all();
    endtask

    task automatic unlock();
        acc(0, 1, 8'h0C, 2'd0, 32'h80);
        acc(0, 1, 8'h0C, 2'd0, 32'h86);
    endtask

    task automatic idle_check();
        @(negedge clk);
        e_kick = 0; e_clr = 0;
        check_all();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        model_reset();
        cur_tag = "R11";
        do_reset();

        cur_tag = "R3";
        acc(0, 1, 8'h00, 2'd2, 32'h0001_2345);           // no unlock: ignored
        cur_tag = "R1";
        unlock();
        acc(0, 1, 8'h00, 2'd2, 32'h1234_5678);           // preload1 = 0x45678
        cur_tag = "R2";
        acc(0, 1, 8'h04, 2'd2, 32'h0000_0ABC);           // unlock used up
        acc(0, 1, 8'h0C, 2'd0, 32'h80);
        acc(0, 1, 8'h0C, 2'd0, 32'h55);                  // stays armed
        acc(0, 1, 8'h0C, 2'd1, 32'h86);                  // opens
        acc(0, 1, 8'h00, 2'd0, 32'h77);                  // byte keeps it open
        acc(0, 0, 8'h0C, 2'd1, 32'h0);                   // read keeps it open
        acc(0, 1, 8'h04, 2'd2, 32'h000A_BCDE);
        cur_tag = "R1";
        acc(0, 1, 8'h0C, 2'd0, 32'h86);                  // not armed
        acc(0, 1, 8'h00, 2'd2, 32'h0000_0001);           // ignored
        cur_tag = "R10";
        acc(0, 1, 8'h0C, 2'd3, 32'h80);                  // reserved size
        acc(0, 1, 8'h0C, 2'd0, 32'h86);
        acc(0, 1, 8'h00, 2'd2, 32'h0000_0002);           // ignored
        cur_tag = "R4";
        unlock();
        acc(0, 1, 8'h0C, 2'd1, 32'h0100);
        idle_check();
        cur_tag = "R5";
        unlock();
        acc(0, 1, 8'h0C, 2'd1, 32'h1000);
        unlock();
        acc(0, 1, 8'h0C, 2'd1, 32'h0300);
        idle_check();
        cur_tag = "R6";
        prev_reboot_in = 1'b1;
        acc(0, 0, 8'h0C, 2'd1, 32'h0);
        acc(0, 0, 8'h0C, 2'd2, 32'h0);
        acc(0, 0, 8'h0C, 2'd1, 32'h0);
        prev_reboot_in = 1'b0;
        acc(0, 0, 8'h0C, 2'd1, 32'h0);
        cur_tag = "R12";
        prev_reboot_in = 1'b1;
        acc(0, 0, 8'h0C, 2'd1, 32'h0);
        acc(1, 1, 8'h60, 2'd1, 32'h0);                   // write: rdata holds
        idle_check();
        prev_reboot_in = 1'b0;
        cur_tag = "R7";
        acc(1, 1, 8'h60, 2'd1, 32'h0025);
        acc(1, 0, 8'h60, 2'd1, 32'h0);
        cur_tag = "R10";
        acc(1, 1, 8'h60, 2'd0, 32'h0000);
        acc(1, 0, 8'h60, 2'd0, 32'h0);
        acc(1, 0, 8'h64, 2'd1, 32'h0);
        acc(1, 1, 8'h68, 2'd1, 32'h0007);
        cur_tag = "R8";
        acc(1, 1, 8'h68, 2'd0, 32'h0006);
        acc(1, 0, 8'h68, 2'd0, 32'h0);
        cur_tag = "R9";
        acc(1, 1, 8'h68, 2'd0, 32'h0001);
        acc(1, 1, 8'h68, 2'd0, 32'h0000);
        acc(1, 0, 8'h68, 2'd0, 32'h0);
        cur_tag = "R11";
        do_reset();

        // random traffic against the model
        cur_tag = "RND";
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 800; i++) begin
            bit [7:0]  a;
            bit [31:0] d;
            bit        cfg;
            bit        wr;
            bit [1:0]  sz;
            if ((i % 160) == 159) begin
                do_reset();
            end
            case ($urandom_range(0, 7))
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h08;
                3, 4: a = 8'h0C;
                5: a = 8'h60;
                6: a = 8'h68;
                default: a = 8'($urandom);
            endcase
            case ($urandom_range(0, 8))
                0, 1: d = 32'h80;
                2, 3: d = 32'h86;
                4: d = 32'h0100;
                5: d = 32'h0200;
                6: d = 32'h1100;
                7: d = $urandom;
                default: d = 32'($urandom_range(0, 63));
            endcase
            cfg = (a >= 8'h60) ? ($urandom_range(0, 4) != 0) : ($urandom_range(0, 7) == 0);
            wr  = ($urandom_range(0, 9) < 7);
            sz  = 2'($urandom_range(0, 3));
            if (a == 8'h68 && cfg && wr && $urandom_range(0, 3) != 0) sz = 2'd0;
            prev_reboot_in = $urandom_range(0, 1) == 1;
            acc(cfg, wr, a, sz, d);
        end
        finish_run();
    end

endmodule